// File: doc/BRIEF.md
# Command and Status Word Unit

This block is the pair of host-visible registers through which a network controller receives commands and reports events. The host writes a command word that carries two opcode fields: one for the transmit/command engine and one for the receive engine. Each nonzero opcode is handed to its engine over a valid/accept handshake. The 32-bit general pointer that was loaded beforehand travels with the opcode. The field reads back nonzero until the engine takes it, so the host can poll for zero before it issues its next command.

The status word collects event flags raised by the engines and by the host's own software-interrupt request. The host clears flags by writing ones to them. An interrupt line is driven whenever an event is pending and the host has not masked it. The low part of the status word carries the live state codes of both engines.

Top module: `cmd_stat_unit`

## Requirements
- R1: After reset the command word reads 0x0100 (interrupt mask set, both opcode fields 0), the status event bits 15:8 read 0, both valid outputs are low and the interrupt output is low.
- R2: A command write with a nonzero command-unit field (bits 7:4) or receive-unit field (bits 2:0) loads that field. In the next cycle the matching valid output is high, the opcode output equals the field and the pointer output equals the general pointer register. These stay unchanged until the engine accepts.
- R3: When valid and accept are both high in a cycle, the field reads 0 and valid is low from the next cycle. The one exception is receive opcode 6.
- R4: A zero value written into an opcode field leaves any pending opcode in that field unchanged. Bit 8 of every command write loads the interrupt mask (1 = masked).
- R5: Receive opcode 6 (load base address) still reads back as 6 after it is accepted, but its valid output drops. A later command write with a nonzero receive field replaces it and raises valid again.
- R6: Input event bits 15, 14, 13, 12, 11 and 8 set the same status bits one cycle later. Input event bits 10, 9 and 7:0 have no effect on the status word.
- R7: A status write with a 1 in an event bit clears that bit, and a 0 leaves it unchanged. If an event sets a bit in the same cycle that a write clears it, the bit stays set.
- R8: A command write with bit 9 set raises status bit 10 (software interrupt) in the next cycle. Bit 9 of the command word always reads 0.
- R9: The interrupt output is high exactly when the mask bit is 0 and at least one status bit among 15:8 is set.
- R10: Status bits 7:6 show the command-unit state input and bits 5:2 show the receive-unit state input in the same cycle. Bits 1:0 read 0.
- R11: A pointer write made while a command is pending does not change the pointer presented with that command. The next command write captures the new value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| hostPtrWr | input | 1 | Write strobe for the general pointer register |
| hostPtrData | input | 32 | Pointer write data |
| hostCmdWr | input | 1 | Command word write strobe |
| hostCmdData | input | 16 | Command word write data |
| hostStatWr | input | 1 | Status word write strobe (write one to clear) |
| hostStatData | input | 16 | Status word write data |
| cmdWord | output | 16 | Command word read-back |
| statWord | output | 16 | Status word read-back |
| irqOut | output | 1 | Interrupt request |
| evtIn | input | 16 | Event pulses from the engines, in status bit positions |
| cuState | input | 2 | Command-unit state code |
| ruState | input | 4 | Receive-unit state code |
| cuValid | output | 1 | Command-unit opcode offered |
| cuOp | output | 4 | Command-unit opcode |
| cuPtr | output | 32 | Pointer captured with the command-unit opcode |
| cuAccept | input | 1 | Command-unit engine takes the opcode |
| ruValid | output | 1 | Receive-unit opcode offered |
| ruOp | output | 3 | Receive-unit opcode |
| ruPtr | output | 32 | Pointer captured with the receive-unit opcode |
| ruAccept | input | 1 | Receive-unit engine takes the opcode |

## Verification
Two pairs of functions can act on the same bit in one cycle. An engine event can set a status bit while a host write clears it, and an acceptance can clear an opcode field while a host write loads it. The bench drives both sides in the same cycle on purpose. It expects the event to survive while the other acknowledged bits clear, and it expects the newly written opcode to stay offered. The sweeps cover every opcode value of both fields and every event bit position, including the positions that must be ignored.

// File: rtl/cmd_stat_pkg.sv
package cmd_stat_pkg;
  localparam int CU_OP_W = 4;
  localparam int RU_OP_W = 3;
  localparam logic [RU_OP_W-1:0] RU_STICKY_OP = 3'd6;
  localparam logic [15:0] HW_EVT_MASK = 16'hF900;
  localparam int SWI_BIT = 10;
  localparam int SWI_REQ_BIT = 9;
  localparam int MASK_BIT = 8;

  typedef struct packed {
    logic loadCu;
    logic loadRu;
    logic clrCu;
    logic clrRu;
    logic loadMask;
    logic setSwi;
    logic ackEvt;
  } strobe_t;
endpackage

// File: rtl/cmd_stat_ctrl.sv
module cmd_stat_ctrl
  import cmd_stat_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  logic               hostCmdWr,
  input  logic [15:0]        hostCmdData,
  input  logic               hostStatWr,
  input  logic [CU_OP_W-1:0] cuField,
  input  logic [RU_OP_W-1:0] ruField,
  input  logic               cuAccept,
  input  logic               ruAccept,
  output logic               cuValid,
  output logic               ruValid,
  output strobe_t            stb
);
  logic ruHeld;
  logic cuWrNz, ruWrNz;
  logic unusedCmdBits;

  assign cuWrNz = hostCmdWr && (hostCmdData[7:4] != '0);
  assign ruWrNz = hostCmdWr && (hostCmdData[2:0] != '0);
  assign unusedCmdBits = ^{hostCmdData[15:10], hostCmdData[3]};

  assign cuValid = (cuField != '0);
  assign ruValid = (ruField != '0) && !ruHeld;

  always_comb begin
    stb          = '0;
    stb.loadCu   = cuWrNz;
    stb.loadRu   = ruWrNz;
    stb.clrCu    = cuValid && cuAccept;
    stb.clrRu    = ruValid && ruAccept && (ruField != RU_STICKY_OP);
    stb.loadMask = hostCmdWr;
    stb.setSwi   = hostCmdWr && hostCmdData[SWI_REQ_BIT];
    stb.ackEvt   = hostStatWr;
  end

  // The sticky receive opcode stays in its field but is offered only once.
  always_ff @(posedge clk) begin
    if (!rstN) begin
      ruHeld <= 1'b0;
    end else if (ruWrNz) begin
      ruHeld <= 1'b0;
    end else if (ruValid && ruAccept && (ruField == RU_STICKY_OP)) begin
      ruHeld <= 1'b1;
    end
  end

  AST_STICKY_NOT_REOFFERED: assert property (@(posedge clk) disable iff (!rstN)
    (ruValid && ruAccept && ruField == RU_STICKY_OP && !ruWrNz) |=> (!ruValid && ruField == RU_STICKY_OP)); // R5
endmodule

// File: rtl/cmd_stat_dpath.sv
module cmd_stat_dpath
  import cmd_stat_pkg::*;
#(
  parameter int PTR_W = 32
) (
  input  logic               clk,
  input  logic               rstN,
  input  strobe_t            stb,
  input  logic [15:0]        hostCmdData,
  input  logic [15:0]        hostStatData,
  input  logic               hostPtrWr,
  input  logic [PTR_W-1:0]   hostPtrData,
  input  logic [15:0]        evtIn,
  output logic [CU_OP_W-1:0] cuField,
  output logic [RU_OP_W-1:0] ruField,
  output logic [PTR_W-1:0]   cuPtrReg,
  output logic [PTR_W-1:0]   ruPtrReg,
  output logic               maskBit,
  output logic [7:0]         evtReg
);
  localparam int EVT_LO = 8;

  logic [PTR_W-1:0] ptrReg;
  logic [15:0] setVec;
  logic [15:0] clrVec;
  logic [7:0] evtNext;

  always_comb begin
    setVec = evtIn & HW_EVT_MASK;
    setVec[SWI_BIT] = stb.setSwi;
    clrVec = stb.ackEvt ? hostStatData : 16'h0000;
  end

  // Clear first, then set, so an event arriving with the acknowledge survives.
  for (genvar b = 0; b < 8; b++) begin : g_evt
    assign evtNext[b] = (evtReg[b] && !clrVec[EVT_LO + b]) || setVec[EVT_LO + b];
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ptrReg   <= '0;
      cuField  <= '0;
      ruField  <= '0;
      cuPtrReg <= '0;
      ruPtrReg <= '0;
      maskBit  <= 1'b1;
      evtReg   <= '0;
    end else begin
      if (hostPtrWr) ptrReg <= hostPtrData;
      if (stb.loadCu) begin
        cuField  <= hostCmdData[7:4];
        cuPtrReg <= ptrReg;
      end else if (stb.clrCu) begin
        cuField <= '0;
      end
      if (stb.loadRu) begin
        ruField  <= hostCmdData[2:0];
        ruPtrReg <= ptrReg;
      end else if (stb.clrRu) begin
        ruField <= '0;
      end
      if (stb.loadMask) maskBit <= hostCmdData[MASK_BIT];
      evtReg <= evtNext;
    end
  end

  AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (!rstN)
    (stb.ackEvt && hostStatData[15] && !evtIn[15]) |=> !evtReg[7]); // R7
  AST_EVENT_WINS: assert property (@(posedge clk) disable iff (!rstN)
    evtIn[14] |=> evtReg[6]); // R6
endmodule

// File: rtl/cmd_stat_unit.sv
module cmd_stat_unit
  import cmd_stat_pkg::*;
#(
  parameter int PTR_W = 32
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               hostPtrWr,
  input  logic [PTR_W-1:0]   hostPtrData,
  input  logic               hostCmdWr,
  input  logic [15:0]        hostCmdData,
  input  logic               hostStatWr,
  input  logic [15:0]        hostStatData,
  output logic [15:0]        cmdWord,
  output logic [15:0]        statWord,
  output logic               irqOut,
  input  logic [15:0]        evtIn,
  input  logic [1:0]         cuState,
  input  logic [3:0]         ruState,
  output logic               cuValid,
  output logic [CU_OP_W-1:0] cuOp,
  output logic [PTR_W-1:0]   cuPtr,
  input  logic               cuAccept,
  output logic               ruValid,
  output logic [RU_OP_W-1:0] ruOp,
  output logic [PTR_W-1:0]   ruPtr,
  input  logic               ruAccept
);
  strobe_t stb;
  logic [CU_OP_W-1:0] cuField;
  logic [RU_OP_W-1:0] ruField;
  logic maskBit;
  logic [7:0] evtReg;

  cmd_stat_ctrl i_ctrl (
    .clk(clk), .rstN(rstN), .hostCmdWr(hostCmdWr), .hostCmdData(hostCmdData),
    .hostStatWr(hostStatWr), .cuField(cuField), .ruField(ruField),
    .cuAccept(cuAccept), .ruAccept(ruAccept), .cuValid(cuValid),
    .ruValid(ruValid), .stb(stb)
  );

  cmd_stat_dpath #(.PTR_W(PTR_W)) i_dpath (
    .clk(clk), .rstN(rstN), .stb(stb), .hostCmdData(hostCmdData),
    .hostStatData(hostStatData), .hostPtrWr(hostPtrWr), .hostPtrData(hostPtrData),
    .evtIn(evtIn), .cuField(cuField), .ruField(ruField), .cuPtrReg(cuPtr),
    .ruPtrReg(ruPtr), .maskBit(maskBit), .evtReg(evtReg)
  );

  assign cuOp     = cuField;
  assign ruOp     = ruField;
  assign cmdWord  = {6'b0, 1'b0, maskBit, cuField, 1'b0, ruField};
  assign statWord = {evtReg[7:2], 1'b0, evtReg[0], cuState, ruState, 2'b00};
  assign irqOut   = !maskBit && (evtReg != '0);

  AST_CU_CLEAR_ON_ACCEPT: assert property (@(posedge clk) disable iff (!rstN)
    (cuValid && cuAccept && !(hostCmdWr && hostCmdData[7:4] != '0)) |=> (!cuValid && cuOp == '0)); // R3
  AST_OFFER_HELD: assert property (@(posedge clk) disable iff (!rstN)
    (cuValid && !cuAccept && !hostCmdWr) |=> (cuValid && $stable(cuOp) && $stable(cuPtr))); // R2
  AST_MASK_SILENCES: assert property (@(posedge clk) disable iff (!rstN)
    cmdWord[MASK_BIT] |-> !irqOut); // R9
  AST_NO_SWI_READBACK: assert property (@(posedge clk) disable iff (!rstN)
    !cmdWord[SWI_REQ_BIT]); // R8
endmodule

// File: tb/test_cmd_stat_unit.sv
module test_cmd_stat_unit;
  logic clk = 0;
  logic rstN = 0;
  logic hostPtrWr = 0;
  logic [31:0] hostPtrData = '0;
  logic hostCmdWr = 0;
  logic [15:0] hostCmdData = '0;
  logic hostStatWr = 0;
  logic [15:0] hostStatData = '0;
  logic [15:0] cmdWord, statWord;
  logic irqOut;
  logic [15:0] evtIn = '0;
  logic [1:0] cuState = '0;
  logic [3:0] ruState = '0;
  logic cuValid, ruValid;
  logic [3:0] cuOp;
  logic [2:0] ruOp;
  logic [31:0] cuPtr, ruPtr;
  logic cuAccept = 0, ruAccept = 0;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  cmd_stat_unit i_cmd_stat_unit (.*);

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wrPtr(input logic [31:0] v);
    hostPtrWr = 1; hostPtrData = v; tick(); hostPtrWr = 0;
  endtask

  task automatic wrCmd(input logic [15:0] v);
    hostCmdWr = 1; hostCmdData = v; tick(); hostCmdWr = 0; hostCmdData = '0;
  endtask

  task automatic wrStat(input logic [15:0] v);
    hostStatWr = 1; hostStatData = v; tick(); hostStatWr = 0; hostStatData = '0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      bad++; total++;
      $display("FAIL watchdog actual=%h expected=%h", 0, 1);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    @(negedge clk); tick(); tick();
    rstN = 1;
    tick();
    // R1 reset state
    chk(cmdWord == 16'h0100, "R1 cmdWord", cmdWord, 16'h0100);
    chk(statWord[15:8] == 0, "R1 events", statWord, 0);
    chk(!cuValid && !ruValid && !irqOut, "R1 valid/irq", {cuValid, ruValid, irqOut}, 0);

    // R2/R3 sweep of every command-unit opcode
    for (int op = 1; op < 16; op++) begin
      logic [31:0] p;
      p = 32'h1000_0000 + op * 32'h0101_0101;
      wrPtr(p);
      wrCmd(16'h0100 | 16'(op << 4));
      chk(cuValid && cuOp == op[3:0], "R2 cu offer", cuOp, op);
      chk(cuPtr == p, "R2 cu pointer", cuPtr, p);
      chk(cmdWord[7:4] == op[3:0], "R2 cu readback", cmdWord, op);
      tick();
      chk(cuValid && cuOp == op[3:0], "R2 cu held", cuOp, op);
      cuAccept = 1; tick(); cuAccept = 0;
      chk(!cuValid && cmdWord[7:4] == 0, "R3 cu cleared", cmdWord, 16'h0100);
    end

    // R2/R3/R5 sweep of every receive-unit opcode
    for (int op = 1; op < 8; op++) begin
      logic [31:0] p;
      p = 32'hA000_0000 + op;
      wrPtr(p);
      wrCmd(16'h0100 | 16'(op));
      chk(ruValid && ruOp == op[2:0], "R2 ru offer", ruOp, op);
      chk(ruPtr == p, "R2 ru pointer", ruPtr, p);
      ruAccept = 1; tick(); ruAccept = 0;
      if (op == 6) begin
        chk(!ruValid && cmdWord[2:0] == 3'd6, "R5 sticky readback", {ruValid, cmdWord[2:0]}, 6);
        tick();
        chk(!ruValid, "R5 not reoffered", ruValid, 0);
      end else begin
        chk(!ruValid && cmdWord[2:0] == 0, "R3 ru cleared", cmdWord, 16'h0100);
      end
    end
    chk(!ruValid && ruOp == 3'd7 - 3'd7, "R5 replaced by 7 then cleared", ruOp, 0);

    // R4 zero field leaves pending opcode; mask loaded on every write
    wrPtr(32'h0000_1111);
    wrCmd(16'h0120);
    wrPtr(32'h0000_2222);       // R11 pointer change while pending
    wrCmd(16'h0003);            // CU field 0, RU 3, mask 0
    chk(cuOp == 4'd2 && cuValid, "R4 cu kept", cuOp, 2);
    chk(cmdWord[8] == 0, "R4 mask loaded", cmdWord, 16'h0023);
    chk(cuPtr == 32'h1111, "R11 pointer kept", cuPtr, 32'h1111);
    chk(ruPtr == 32'h2222, "R11 new capture", ruPtr, 32'h2222);
    // load and accept in the same cycle: the new opcode stays offered
    hostCmdWr = 1; hostCmdData = 16'h0050; cuAccept = 1; ruAccept = 1;
    tick();
    hostCmdWr = 0; hostCmdData = '0; cuAccept = 0; ruAccept = 0;
    chk(cuValid && cuOp == 4'd5, "R3 load beats accept", cuOp, 5);
    chk(!ruValid && ruOp == 0, "R3 ru accepted", ruOp, 0);
    cuAccept = 1; tick(); cuAccept = 0;

    // R6/R7/R9 sweep of every hardware event bit (mask is 0)
    for (int b = 0; b < 16; b++) begin
      logic [15:0] hw;
      hw = 16'h1 << b;
      evtIn = hw; tick(); evtIn = '0;
      if ((16'hF900 & hw) != 0) begin
        chk(statWord[15:8] == hw[15:8], "R6 event set", statWord, hw);
        chk(irqOut, "R9 irq raised", irqOut, 1);
        wrStat(hw);
        chk(statWord[15:8] == 0, "R7 ack clears", statWord, 0);
        chk(!irqOut, "R9 irq dropped", irqOut, 1'b0);
      end else begin
        chk(statWord[15:8] == 0 && !irqOut, "R6 ignored bit", statWord, 0);
      end
    end

    // R7 write of zero leaves bits; set wins over same-cycle clear
    evtIn = 16'h4800; tick(); evtIn = '0;
    wrStat(16'h0000);
    chk(statWord[15:8] == 8'h48, "R7 zero write", statWord[15:8], 8'h48);
    evtIn = 16'h4000; hostStatWr = 1; hostStatData = 16'hFD00;
    tick();
    evtIn = '0; hostStatWr = 0; hostStatData = '0;
    chk(statWord[15:8] == 8'h40, "R7 set wins", statWord[15:8], 8'h40);
    wrStat(16'h4000);

    // R8 software interrupt, R9 masking
    wrCmd(16'h0200);
    chk(statWord[10] && cmdWord[9] == 0, "R8 swi", {statWord[10], cmdWord[9]}, 2);
    chk(irqOut, "R9 swi irq", irqOut, 1);
    wrCmd(16'h0100);
    chk(!irqOut && statWord[10], "R9 masked", irqOut, 0);
    wrStat(16'h0400);
    chk(statWord[15:8] == 0, "R8 swi acked", statWord, 0);

    // R10 state fields
    for (int c = 0; c < 4; c++) begin
      for (int r = 0; r < 16; r++) begin
        cuState = c[1:0]; ruState = r[3:0];
        #1;
        chk(statWord[7:0] == {c[1:0], r[3:0], 2'b00}, "R10 state", statWord, {c[1:0], r[3:0], 2'b00});
      end
    end

    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule